// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is the slave side of a two-wire serial memory. It watches SCL and SDA with a faster system clock and finds start and stop conditions. It matches a device address made of a fixed four-bit prefix and three strap pins. A write-type address byte is followed by two word-address bytes that load a 13-bit byte address. Data bytes after those are stored one after another. A read-type address byte returns bytes from the internal address register, one byte after another, for as long as the master acknowledges.

The address register keeps its value from one transaction to the next, so a read that starts with no address phase continues right after the last byte that was touched. A special master code switches on a high-speed flag, which stays set until the next stop. Writes finish at once, and the slave never holds the bus busy.

The storage sits inside the block as a synchronous RAM of 2^MEM_AW bytes. The 13-bit address folds onto that RAM by its low MEM_AW bits. With MEM_AW = 13 the block holds the full 8192 bytes. The default size is kept small so that elaboration stays light.

Top module: `i2c_fram_slave`

## Requirements
- R1: After reset, sda_oe_o and hs_mode_o are 0 and the address register is 0, so a current-address read as the first access returns the byte at address 0.
- R2: A device byte is acknowledged (sda_oe_o pulls SDA low on the ninth clock) only when its bits 7:4 are 1010 and its bits 3:1 equal strap_i. Bit 0 selects read (1) or write (0). On a mismatch the slave gives no acknowledge, and every byte after it is ignored until the next start.
- R3: After a write-type device byte, two word-address bytes follow. Bits 4:0 of the first byte give A12..A8 and its bits 7:5 are ignored. The second byte gives A7..A0. The slave acknowledges both.
- R4: In a write, each data byte after the word address is acknowledged, stored at the current address, and the address then increments.
- R5: In a random read (address phase, repeated start, read-type device byte), the first byte returned is the one at the loaded address, sent MSB first.
- R6: When the master acknowledges a returned byte, the slave sends the byte at the next address.
- R7: The address increments from 8191 to 0, for reads and for writes alike.
- R8: A read with no address phase returns the byte after the last byte read or written.
- R9: A byte of the form 00001xxx right after a start is not acknowledged and sets hs_mode_o. The flag stays set across a repeated start and clears on a stop. A normal command after the repeated start works as usual.
- R10: Bytes clocked after a stop and before the next start get no acknowledge and change neither storage nor the address.
- R11: When the master does not acknowledge a returned byte, the slave releases SDA and drives nothing more until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It samples the bus and must run much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, as seen at the pad |
| sda_i | input | 1 | Serial data line, as seen at the pad (wired-AND level) |
| strap_i | input | 3 | Strap pins that set the device address bits 3:1 |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low. When 0, SDA is released |
| hs_mode_o | output | 1 | High-speed mode flag |

## Verification
Address wrap and folding are the hardest cases to reach from the pins. To check that the slave continues from address 0 after address 8191, a write burst and then a sequential read must both be started right at the top address. Address 0 must then be read again on its own, to show that the second byte of the burst landed there and not past the end. The bench reaches this with a two-byte write at 8191, a two-byte read from the same address, and a single read at 0. It also checks current-address reads after a mismatched device byte, after a high-speed code and after a NACK, so that any address change caused by those paths shows up in the byte that comes back.

// File: rtl/i2c_fram_pkg.sv
package i2c_fram_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 13;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam logic [4:0] HS_CODE = 5'b00001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_WHI,
        RX_WLO,
        RX_DAT
    } rxk_e;

    typedef struct packed {
        st_e               st;
        rxk_e              rxk;
        logic [3:0]        bit_cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] txreg;
        logic [ADDR_W-1:0] addr;
        logic [HI_W-1:0]   ahi;
        logic              nxt_tx;
        logic              mack;
        logic              hs;
        logic              sda_oe;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st:      ST_IDLE,
        rxk:     RX_DEV,
        bit_cnt: 4'd0,
        shreg:   '0,
        txreg:   '0,
        addr:    '0,
        ahi:     '0,
        nxt_tx:  1'b0,
        mack:    1'b0,
        hs:      1'b0,
        sda_oe:  1'b0
    };
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sh_q;
    logic [STAGES-1:0] sda_sh_q;
    logic              scl_prev_q;
    logic              sda_prev_q;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q   <= '1;
            sda_sh_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sh_q[STAGES-1];
            sda_prev_q <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_now    = scl_sh_q[STAGES-1];
    assign sda_now    = sda_sh_q[STAGES-1];
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev_q;
    assign scl_fall_o = ~scl_now & scl_prev_q;
    assign start_o    = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
    assign stop_o     = scl_now & scl_prev_q & ~sda_prev_q & sda_now;
endmodule

// File: rtl/i2c_fram_array.sv
module i2c_fram_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_o <= mem_q[raddr_i];
    end
endmodule

// File: rtl/i2c_fram_slave.sv
module i2c_fram_slave
    import i2c_fram_pkg::*;
#(
    parameter int         MEM_AW      = 9,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o,
    output logic       hs_mode_o
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_rdata;

    ctrl_t q, d;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2c_fram_array #(.AW(MEM_AW), .DW(BYTE_W)) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (q.addr[MEM_AW-1:0]),
        .wdata_i (q.shreg),
        .raddr_i (q.addr[MEM_AW-1:0]),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        case (q.st)
            ST_RX: begin
                if (scl_rise) begin
                    d.shreg   = {q.shreg[BYTE_W-2:0], sda_s};
                    d.bit_cnt = q.bit_cnt + 4'd1;
                end else if (scl_fall && q.bit_cnt == 4'd8) begin
                    d.bit_cnt = 4'd0;
                    d.nxt_tx  = 1'b0;
                    case (q.rxk)
                        RX_DEV: begin
                            if (q.shreg[7:4] == DEV_PREFIX && q.shreg[3:1] == strap_i) begin
                                d.st     = ST_ACK;
                                d.sda_oe = 1'b1;
                                d.nxt_tx = q.shreg[0];
                                d.rxk    = RX_WHI;
                            end else if (q.shreg[7:3] == HS_CODE) begin
                                d.hs = 1'b1;
                                d.st = ST_IDLE;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end
                        RX_WHI: begin
                            d.ahi    = q.shreg[HI_W-1:0];
                            d.st     = ST_ACK;
                            d.sda_oe = 1'b1;
                            d.rxk    = RX_WLO;
                        end
                        RX_WLO: begin
                            d.addr   = {q.ahi, q.shreg};
                            d.st     = ST_ACK;
                            d.sda_oe = 1'b1;
                            d.rxk    = RX_DAT;
                        end
                        default: begin
                            mem_we   = 1'b1;
                            d.addr   = q.addr + ADDR_ONE;
                            d.st     = ST_ACK;
                            d.sda_oe = 1'b1;
                        end
                    endcase
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    d.bit_cnt = 4'd0;
                    if (q.nxt_tx) begin
                        d.txreg  = mem_rdata;
                        d.addr   = q.addr + ADDR_ONE;
                        d.sda_oe = ~mem_rdata[BYTE_W-1];
                        d.st     = ST_TX;
                    end else begin
                        d.sda_oe = 1'b0;
                        d.st     = ST_RX;
                    end
                end
            end
            ST_TX: begin
                if (scl_fall) begin
                    if (q.bit_cnt == 4'd7) begin
                        d.sda_oe = 1'b0;
                        d.mack   = 1'b0;
                        d.st     = ST_MACK;
                    end else begin
                        d.txreg   = {q.txreg[BYTE_W-2:0], 1'b0};
                        d.sda_oe  = ~q.txreg[BYTE_W-2];
                        d.bit_cnt = q.bit_cnt + 4'd1;
                    end
                end
            end
            ST_MACK: begin
                if (scl_rise) begin
                    d.mack = ~sda_s;
                end else if (scl_fall) begin
                    d.bit_cnt = 4'd0;
                    if (q.mack) begin
                        d.txreg  = mem_rdata;
                        d.addr   = q.addr + ADDR_ONE;
                        d.sda_oe = ~mem_rdata[BYTE_W-1];
                        d.st     = ST_TX;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: begin
            end
        endcase

        if (start_evt) begin
            d.st      = ST_RX;
            d.rxk     = RX_DEV;
            d.bit_cnt = 4'd0;
            d.sda_oe  = 1'b0;
        end
        if (stop_evt) begin
            d.st     = ST_IDLE;
            d.hs     = 1'b0;
            d.sda_oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTRL_RST;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.sda_oe;
    assign hs_mode_o = q.hs;
endmodule

// File: rtl/i2c_fram_slave_chk.sv
module i2c_fram_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe_o,
    input logic hs_mode_o,
    input logic scl_fall_evt,
    input logic start_evt,
    input logic stop_evt
);
    // R1: outputs quiet in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sda_oe_o && !hs_mode_o));

    // R2: the SDA drive only moves after an SCL fall or a bus condition
    a_r2_drive_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> ($past(scl_fall_evt) || $past(start_evt) || $past(stop_evt)));

    // R10: a stop leaves SDA released
    a_r10_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe_o);

    // R9: the high-speed flag clears on stop
    a_r9_hs_cleared_by_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !hs_mode_o);

    // R9: the high-speed code is never acknowledged
    a_r9_hs_code_not_acked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode_o) |-> !sda_oe_o);
endmodule

bind i2c_fram_slave i2c_fram_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_oe_o     (sda_oe_o),
    .hs_mode_o    (hs_mode_o),
    .scl_fall_evt (scl_fall),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt)
);

// File: tb/tb_i2c_fram_slave.sv
module tb_i2c_fram_slave;
    localparam int MAW = 9;
    localparam int Q   = 8;
    localparam logic [2:0] STRAP = 3'b010;
    // {junk bits for word byte 1, address, data}
    localparam int NV = 6;
    localparam logic [23:0] VEC [NV] = '{
        {3'b000, 13'h0000, 8'h11},
        {3'b111, 13'h0005, 8'hC3},
        {3'b101, 13'h1234, 8'h80},
        {3'b010, 13'h0AAA, 8'h01},
        {3'b000, 13'h1F00, 8'hFF},
        {3'b110, 13'h0033, 8'h5E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic [2:0] strap = STRAP;
    logic sda_oe, hs;
    logic sda_line;
    int n_tests = 0;
    int n_fail = 0;
    logic [7:0] mdl [1 << MAW];
    logic [12:0] next_addr;

    assign sda_line = !(m_low || sda_oe);

    always #4 clk = ~clk;

    i2c_fram_slave #(.MEM_AW(MAW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .strap_i   (strap),
        .sda_oe_o  (sda_oe),
        .hs_mode_o (hs)
    );

    function automatic int ix(input logic [12:0] a);
        return int'(a[MAW-1:0]);
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        m_low = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(Q);
            scl = 1'b1; wq(2*Q);
            scl = 1'b0; wq(Q);
        end
        m_low = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl = 1'b0; wq(Q);
        end
        m_low = give_ack; wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(2);
        m_low = 1'b0;
    endtask

    task automatic addr_phase(input logic [12:0] a, input logic [2:0] junk, input string tag);
        logic ack;
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        chk(ack, {tag, " R2 device ack"}, ack, 1);
        send_byte({junk, a[12:8]}, ack);
        chk(ack, {tag, " R3 word byte 1 ack"}, ack, 1);
        send_byte(a[7:0], ack);
        chk(ack, {tag, " R3 word byte 2 ack"}, ack, 1);
    endtask

    task automatic write_run(input logic [12:0] a, input logic [2:0] junk, input int n,
                             input logic [7:0] base);
        logic ack;
        logic [12:0] p;
        addr_phase(a, junk, "write");
        p = a;
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i * 17), ack);
            chk(ack, "R4 data ack", ack, 1);
            mdl[ix(p)] = base + 8'(i * 17);
            p = p + 13'd1;
        end
        i2c_stop();
        next_addr = p;
    endtask

    task automatic read_bytes(input int n, input string tag);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b === mdl[ix(next_addr)], tag, b, mdl[ix(next_addr)]);
            next_addr = next_addr + 13'd1;
        end
        i2c_stop();
    endtask

    task automatic read_at(input logic [12:0] a, input int n, input string tag);
        logic ack;
        addr_phase(a, 3'b000, tag);
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk(ack, {tag, " R2 read device ack"}, ack, 1);
        next_addr = a;
        read_bytes(n, tag);
    endtask

    task automatic cur_read(input int n, input string tag);
        logic ack;
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk(ack, {tag, " R2 read device ack"}, ack, 1);
        read_bytes(n, tag);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        next_addr = 13'd0;
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R1 reset state
        chk(!sda_oe && !hs, "R1 outputs after reset", {sda_oe, hs}, 0);

        // table: write one byte then random read it back (R4, R5, R3)
        for (int v = 0; v < NV; v++) begin
            write_run(VEC[v][20:8], VEC[v][23:21], 1, VEC[v][7:0]);
            read_at(VEC[v][20:8], 1, "R5 random read");
            chk(mdl[ix(VEC[v][20:8])] === VEC[v][7:0], "R4 table store", mdl[ix(VEC[v][20:8])], VEC[v][7:0]);
        end

        // R6 sequential write and read
        write_run(13'h0100, 3'b000, 3, 8'h3C);
        read_at(13'h0100, 3, "R6 sequential read");

        // R7 wrap from 8191 to 0
        write_run(13'h1FFF, 3'b000, 2, 8'h77);
        read_at(13'h1FFF, 2, "R7 wrap read");
        read_at(13'h0000, 1, "R7 wrapped write landed at 0");

        // R8 current-address reads
        read_at(13'h0100, 1, "R5 single read");
        cur_read(1, "R8 after read");
        write_run(13'h0004, 3'b000, 1, 8'hA5);
        cur_read(2, "R8 after write");

        // R2 strap mismatch: nothing acked, nothing stored
        i2c_start();
        send_byte({4'b1010, 3'b101, 1'b0}, ack);
        chk(!ack, "R2 mismatch no ack", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R2 ignored word byte", ack, 0);
        send_byte(8'h00, ack);
        send_byte(8'hEE, ack);
        chk(!ack, "R2 ignored data byte", ack, 0);
        i2c_stop();
        cur_read(1, "R2 address untouched");
        read_at(13'h0000, 1, "R2 storage untouched");

        // R9 high-speed code
        i2c_start();
        send_byte(8'h0D, ack);
        chk(!ack, "R9 hs code not acked", ack, 0);
        chk(hs, "R9 hs flag set", hs, 1);
        i2c_start();
        chk(hs, "R9 hs kept on repeated start", hs, 1);
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk(ack, "R9 command after hs acked", ack, 1);
        read_bytes(1, "R9 read in hs");
        chk(!hs, "R9 hs cleared by stop", hs, 0);

        // R10 bytes with no start
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        chk(!ack, "R10 no start no ack", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R10 no start second byte", ack, 0);
        cur_read(1, "R10 address untouched");

        // R11 NACK ends the read
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        recv_byte(1'b0, b);
        chk(b === mdl[ix(next_addr)], "R11 byte before nack", b, mdl[ix(next_addr)]);
        next_addr = next_addr + 13'd1;
        recv_byte(1'b0, b);
        chk(b === 8'hFF, "R11 bus released after nack", b, 8'hFF);
        chk(!sda_oe, "R11 no drive after nack", sda_oe, 0);
        i2c_stop();
        cur_read(1, "R11 address after nack");

        // R1 address register cleared by reset
        write_run(13'h0000, 3'b000, 1, 8'h5A);
        write_run(13'h0040, 3'b000, 1, 8'h9B);
        wq(4);
        rst_n = 1'b0;
        wq(4);
        rst_n = 1'b1;
        wq(4);
        chk(!sda_oe && !hs, "R1 outputs after second reset", {sda_oe, hs}, 0);
        next_addr = 13'd0;
        cur_read(1, "R1 address zero after reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule